// File: doc/BRIEF.md
# Reference-Pulse Disciplined Sample Trigger

This block produces a periodic sample-start pulse whose rate follows a once-per-second timing reference. A free-running counter on the system clock is captured on every synchronized rising edge of the reference. The difference between two consecutive captures, taken modulo the counter range, gives the true number of clock cycles in one reference period. That figure is reported with a one-cycle strobe. It is then divided by the requested samples-per-second to get the sample interval in clock cycles.

The sample-start output is a pulse train. Each interval begins with a high phase of programmable length and then stays low until the interval ends. Every reference rising edge restarts the pulse train, so the first pulse after each edge lines up with the reference. A newly computed interval takes effect only at a reference edge.

Implausible periods are discarded. If the reference goes quiet, a missing flag is raised and the pulse train keeps running at the last interval. When the reference returns, measurement starts again from a fresh first capture.

Top module: `pps_sample_trigger`

## Requirements
- R1: While reset is held, `period_valid_o` and `ref_lost_o` are 0. The pulse train is at phase 0, so `sample_o` is high when `width_i` > 0. The interval is NOMINAL/DEF_SPS cycles.
- R2: The counter is never cleared by the reference. `period_o` equals the number of clock cycles between two consecutive synchronized rising edges of `ref_i`, modulo 2^CNT_W, and stays correct across counter wrap. `period_valid_o` pulses for one cycle, two clock edges after the edge that first samples `ref_i` high.
- R3: The first rising edge after reset, and the first one after the reference was declared missing, produces no `period_valid_o` strobe.
- R4: A period outside NOMINAL ± NOMINAL/100 (bounds inclusive) produces no strobe and does not change the sample interval.
- R5: An accepted period P gives a new interval of floor(P / `sps_i`) cycles, using the `sps_i` value at the strobe. The new interval takes effect only at the next reference rising edge.
- R6: If `sps_i` is 0 when a period is accepted, the interval is not changed.
- R7: Each reference rising edge restarts the pulse train at phase 0, on the same clock edge as the strobe. `sample_o` is then high for exactly `width_i` cycles and low for the rest of the interval.
- R8: `ref_lost_o` rises after 1.5×NOMINAL cycles without a rising edge. It clears at the next rising edge.
- R9: While the reference is missing, `sample_o` keeps repeating at the last applied interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock driving the timebase |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Raw once-per-second reference pulse, asynchronous |
| sps_i | input | SPS_W | Samples per second requested |
| width_i | input | CNT_W | High time of each sample pulse in cycles |
| period_o | output | CNT_W | Last accepted reference period in cycles |
| period_valid_o | output | 1 | One-cycle strobe for a new accepted period |
| ref_lost_o | output | 1 | Reference missing flag |
| sample_o | output | 1 | Sample-start pulse train |

## Verification
Assertions check on every cycle that:
- any strobed period lies inside the tolerance window and is never flagged while the reference counts as lost;
- the interval changes only on a reference edge;
- each edge puts the pulse phase back to zero;
- the phase never leaves its interval;
- the divider never runs with a zero divisor.

Only the bench scenarios can show:
- the period value across counter wrap;
- the silent first capture after reset and after loss;
- the floor division and the one-edge delay before a new interval applies;
- the exact high time after each edge;
- the loss timeout and holdover spacing.

// File: rtl/pps_trig_pkg.sv
package pps_trig_pkg;
  typedef enum logic {DIV_IDLE, DIV_RUN} div_state_e;
endpackage

// File: rtl/pps_edge_capture.sv
module pps_edge_capture #(
  parameter int CNT_W    = 32,
  parameter int NOMINAL  = 100_000_000,
  parameter int SYNC_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  output logic             rise_o,
  output logic [CNT_W-1:0] period_o,
  output logic             period_valid_o,
  output logic             ref_lost_o
);
  localparam int MISS  = NOMINAL + NOMINAL / 2;
  localparam int TOL   = NOMINAL / 100;
  localparam int GAP_W = $clog2(MISS + 1);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(NOMINAL - TOL);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(NOMINAL + TOL);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(SYNC_LAT);
  localparam logic [GAP_W-1:0] MISS_C = GAP_W'(MISS);

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q, last_q, period_q, cap, diff;
  logic [GAP_W-1:0] gap_q;
  logic             have_prev_q, valid_q, lost, in_range;

  assign rise_o   = sync_q[1] & ~sync_q[2];
  assign cap      = cnt_q - LAT_C;   // common offset for all captures
  assign diff     = cap - last_q;    // modulo 2^CNT_W
  assign in_range = (diff >= LO_C) && (diff <= HI_C);
  assign lost     = (gap_q == MISS_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q      <= '0;
      cnt_q       <= '0;
      last_q      <= '0;
      period_q    <= '0;
      gap_q       <= '0;
      have_prev_q <= 1'b0;
      valid_q     <= 1'b0;
    end else begin
      sync_q  <= {sync_q[1:0], ref_i};
      cnt_q   <= cnt_q + 1'b1;
      valid_q <= 1'b0;
      if (rise_o) begin
        last_q      <= cap;
        gap_q       <= '0;
        have_prev_q <= 1'b1;
        if (have_prev_q && !lost && in_range) begin
          period_q <= diff;
          valid_q  <= 1'b1;
        end
      end else if (lost) begin
        have_prev_q <= 1'b0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign period_o       = period_q;
  assign period_valid_o = valid_q;
  assign ref_lost_o     = lost;

  assert_valid_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_valid_o |-> (period_o >= LO_C && period_o <= HI_C));
  assert_valid_not_lost_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_valid_o |-> !ref_lost_o);
endmodule

// File: rtl/pps_int_div.sv
module pps_int_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  import pps_trig_pkg::*;
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam logic [STEP_W-1:0] LAST_C = STEP_W'(NUM_W - 1);

  div_state_e        state_q;
  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W-1:0]  rem_q, den_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q, ge;
  logic [DEN_W:0]    rem_sh, rem_nx;

  assign rem_sh = {rem_q, quo_q[NUM_W-1]};
  assign ge     = rem_sh >= {1'b0, den_q};
  assign rem_nx = ge ? rem_sh - {1'b0, den_q} : rem_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      quo_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == DIV_IDLE) begin
        if (start_i && den_i != '0) begin
          state_q <= DIV_RUN;
          quo_q   <= num_i;
          rem_q   <= '0;
          den_q   <= den_i;
          step_q  <= '0;
        end
      end else begin
        rem_q  <= rem_nx[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], ge};
        step_q <= step_q + 1'b1;
        if (step_q == LAST_C) begin
          state_q <= DIV_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  assert_div_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == DIV_RUN) |-> (den_q != '0));
endmodule

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen #(
  parameter int CNT_W    = 32,
  parameter int INIT_IVL = 100_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] upd_val_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             sample_o
);
  localparam logic [CNT_W-1:0] INIT_C = CNT_W'(INIT_IVL);

  logic [CNT_W-1:0] phase_q, ivl_q, pend_q;
  logic             pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= '0;
      ivl_q    <= INIT_C;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      if (restart_i) begin
        phase_q <= '0;
        if (pend_v_q) begin
          ivl_q    <= pend_q;
          pend_v_q <= 1'b0;
        end
      end else if (phase_q == ivl_q - 1'b1) begin
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
      if (upd_i && upd_val_i != '0) begin
        pend_q   <= upd_val_i;
        pend_v_q <= 1'b1;
      end
    end
  end

  assign sample_o = phase_q < width_i;

  assert_ivl_at_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> $stable(ivl_q));
  assert_restart_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (phase_q == '0));
  assert_phase_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < ivl_q);
endmodule

// File: rtl/pps_sample_trigger.sv
module pps_sample_trigger #(
  parameter int CNT_W    = 32,
  parameter int NOMINAL  = 100_000_000,
  parameter int SPS_W    = 16,
  parameter int DEF_SPS  = 1000,
  parameter int SYNC_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [SPS_W-1:0] sps_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [CNT_W-1:0] period_o,
  output logic             period_valid_o,
  output logic             ref_lost_o,
  output logic             sample_o
);
  localparam int INIT_IVL = NOMINAL / DEF_SPS;

  logic             rise, div_done;
  logic [CNT_W-1:0] quo;

  pps_edge_capture #(.CNT_W(CNT_W), .NOMINAL(NOMINAL), .SYNC_LAT(SYNC_LAT)) u_cap (
    .clk_i, .rst_ni, .ref_i,
    .rise_o(rise), .period_o, .period_valid_o, .ref_lost_o
  );

  pps_int_div #(.NUM_W(CNT_W), .DEN_W(SPS_W)) u_div (
    .clk_i, .rst_ni,
    .start_i(period_valid_o), .num_i(period_o), .den_i(sps_i),
    .done_o(div_done), .quo_o(quo)
  );

  pps_pulse_gen #(.CNT_W(CNT_W), .INIT_IVL(INIT_IVL)) u_gen (
    .clk_i, .rst_ni,
    .restart_i(rise), .upd_i(div_done), .upd_val_i(quo),
    .width_i, .sample_o
  );
endmodule

// File: tb/pps_sample_trigger_tb.sv
module pps_sample_trigger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int W  = 3;

  logic clk_i = 0, rst_ni = 0, ref_i = 0;
  logic [7:0] sps_i = 8'd8;
  logic [CW-1:0] width_i = CW'(W);
  logic [CW-1:0] period_o;
  logic period_valid_o, ref_lost_o, sample_o;

  int n_run = 0, n_fail = 0;
  int cyc = 0, vcnt = 0, last_p = 0, spacing = 0, last_rise = 0;
  logic prev_s = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pps_sample_trigger #(.CNT_W(CW), .NOMINAL(1000), .SPS_W(8), .DEF_SPS(10)) dut_i (
    .clk_i, .rst_ni, .ref_i, .sps_i, .width_i,
    .period_o, .period_valid_o, .ref_lost_o, .sample_o
  );

  always @(negedge clk_i) begin
    cyc++;
    if (period_valid_o) begin vcnt++; last_p = int'(period_o); end
    if (sample_o && !prev_s) begin spacing = cyc - last_rise; last_rise = cyc; end
    prev_s = sample_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // rise now, check alignment and width, then hold until the next rise slot
  task automatic ref_cycle(input int gap);
    ref_i = 1;
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < W; k++) begin
      chk(sample_o == 1'b1, "R7 high after edge", int'(sample_o), 1);
      @(negedge clk_i);
    end
    chk(sample_o == 1'b0, "R7 low after width", int'(sample_o), 0);
    repeat (20 - 3 - W) @(negedge clk_i);
    ref_i = 0;
    repeat (gap - 20) @(negedge clk_i);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk(sample_o == 1'b1, "R1 sample", int'(sample_o), 1);
    chk(ref_lost_o == 1'b0, "R1 lost", int'(ref_lost_o), 0);
    chk(period_valid_o == 1'b0, "R1 valid", int'(period_valid_o), 0);
    rst_ni = 1;
    repeat (400) @(negedge clk_i);
    chk(spacing == 100, "R1 default interval", spacing, 100);
  endtask

  task automatic t_measure;
    ref_cycle(1000);
    chk(vcnt == 0, "R3 first capture silent", vcnt, 0);
    chk(spacing == 100, "R5 old interval", spacing, 100);
    ref_cycle(1000);
    chk(vcnt == 1, "R2 strobe", vcnt, 1);
    chk(last_p == 1000, "R2 period", last_p, 1000);
    chk(spacing == 100, "R5 not before edge", spacing, 100);
    sps_i = 8'd3;
    ref_cycle(1000);
    chk(spacing == 125, "R5 1000/8", spacing, 125);
    ref_cycle(1005);
    chk(spacing == 333, "R5 floor 1000/3", spacing, 333);
    sps_i = 8'd10;
    ref_cycle(1050);
    chk(last_p == 1005, "R2 period wrap", last_p, 1005);
    chk(vcnt == 4, "R2 count", vcnt, 4);
  endtask

  task automatic t_reject;
    ref_cycle(1000);
    chk(vcnt == 4, "R4 reject 1050", vcnt, 4);
    chk(spacing == 100, "R5 1005/10", spacing, 100);
    sps_i = 8'd5;
    ref_cycle(1000);
    chk(vcnt == 5, "R2 after reject", vcnt, 5);
    chk(spacing == 100, "R4 interval unchanged", spacing, 100);
  endtask

  task automatic t_zero_and_loss;
    sps_i = 8'd0;
    ref_cycle(1000);
    chk(spacing == 200, "R5 1000/5", spacing, 200);
    ref_cycle(1400);
    chk(spacing == 200, "R6 sps zero keeps", spacing, 200);
    chk(ref_lost_o == 1'b0, "R8 not yet lost", int'(ref_lost_o), 0);
    repeat (200) @(negedge clk_i);
    chk(ref_lost_o == 1'b1, "R8 lost", int'(ref_lost_o), 1);
    repeat (400) @(negedge clk_i);
    chk(spacing == 200, "R9 holdover", spacing, 200);
    sps_i = 8'd10;
    ref_cycle(1000);
    chk(vcnt == 7, "R3 silent after loss", vcnt, 7);
    chk(ref_lost_o == 1'b0, "R8 cleared", int'(ref_lost_o), 0);
    ref_cycle(1000);
    chk(vcnt == 8, "R3 resumes", vcnt, 8);
    chk(last_p == 1000, "R2 period after loss", last_p, 1000);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_measure();
    t_reject();
    t_zero_and_loss();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule